// File: doc/BRIEF.md
# Pull-in and Hold PWM Gate Controller

This block drives the gate of a low-side switch that feeds a solenoid, valve or heater. A level-sensitive enable starts each drive cycle. After enable rises, the gate is held fully on for a programmable number of clocks. This pull-in phase gives an actuator its strong initial closure. The block then moves to a hold phase, where the gate follows a pulse-width-modulated waveform and the load draws less average power.

The PWM waveform comes from a period counter that runs all the time and ignores enable. Because the two are not aligned, the first hold pulse after pull-in may be cut short. The duty request is a 7-bit percentage. It is clamped to the 10%..90% window and turned into an on-time in clocks. The on-time is reloaded only when a period ends, so a period in progress is never reshaped. A select input picks one of three delay behaviours: a timed pull-in, no pull-in at all, or a pull-in that lasts for as long as enable stays high.

The controller is a three-state machine with the states OFF, PULLIN and PWM. Its transitions are:
- enable-rise-timed (OFF to PULLIN)
- enable-rise-minimum (OFF to PWM)
- pull-in-done (PULLIN to PWM)
- minimum-select during pull-in (PULLIN to PWM)
- enable-drop (PULLIN or PWM to OFF)

Top module: `pullin_pwm_ctrl`

## Requirements
- R1: When enable is sampled low at a clock edge, the state becomes OFF at that edge, so from then on the gate is 0 and the mode output reads OFF.
- R2: With delay select 2'b00 (timed; 2'b11 acts the same), enable sampled high in OFF moves to PULLIN. The gate is then held at 1 for max(pull_len,1) clocks, after which the state is PWM.
- R3: The period counter counts 0..P-1 and wraps, whatever enable does. In PWM the gate is 1 exactly while the count is below the current on-time, so the first hold pulse may be partial.
- R4: The on-time is P*D/100 clocks, rounded down. D is the 7-bit duty input clamped to 10..90, so any window of P clocks in PWM holds that many gate-high clocks.
- R5: A new on-time is loaded only in the clock where the counter wraps. A duty change takes effect from the next period start.
- R6: Delay select 2'b10 (infinite) keeps the state in PULLIN with the gate at 1 while enable stays high; PWM is never entered.
- R7: Delay select 2'b01 (minimum) moves from OFF to PWM at the first edge that samples enable high. The same select, seen during PULLIN, moves to PWM at the next edge.
- R8: Dropping enable clears the pull-in timer, so each later rise starts a full new pull-in interval.
- R9: The mode output is 2'b00 for OFF, 2'b01 for PULLIN and 2'b10 for PWM, and never reads 2'b11.
- R10: Period values below 2 are treated as 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Level-sensitive drive request |
| pull_len | input | PULL_W | Pull-in length in clocks |
| delay_sel | input | 2 | 00 timed, 01 minimum, 10 infinite, 11 timed |
| period | input | PERIOD_W | PWM period in clocks |
| duty | input | 7 | Duty request in percent |
| gate | output | 1 | Gate drive |
| mode | output | 2 | Current state: 00 OFF, 01 PULLIN, 10 PWM |

## Verification
A behavioural reference model steps alongside the design on every clock and is compared with it. The main function is tried with several duty values:
- Mid-range values show the on-time arithmetic.
- Values below 10 and above 90 show the clamp, telling clamping apart from plain scaling.
- A duty change during hold separates reload at the period boundary from immediate reload.

Enable is raised at different offsets from the counter phase. This tells a free-running counter apart from one restarted by enable. Separate phases cover:
- each delay select;
- an enable drop during pull-in followed by a new rise, which tells a cleared timer from a resumed one;
- a period of 1, which exercises the lower period limit.

// File: rtl/pph_pkg.sv
package pph_pkg;
    typedef enum logic [1:0] {
        ST_OFF    = 2'b00,
        ST_PULLIN = 2'b01,
        ST_PWM    = 2'b10
    } pph_state_t;

    localparam logic [1:0] SEL_TIMED    = 2'b00;
    localparam logic [1:0] SEL_MINIMUM  = 2'b01;
    localparam logic [1:0] SEL_INFINITE = 2'b10;

    localparam int DUTY_W   = 7;
    localparam int DUTY_LO  = 10;
    localparam int DUTY_HI  = 90;
    localparam int MIN_PER  = 2;
endpackage

// File: rtl/pph_oscillator.sv
module pph_oscillator #(
    parameter int PERIOD_W = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [PERIOD_W-1:0] period,
    output logic [PERIOD_W-1:0] count,
    output logic [PERIOD_W-1:0] per_eff,
    output logic                wrap
);
    import pph_pkg::*;

    localparam logic [PERIOD_W-1:0] PER_FLOOR = PERIOD_W'(MIN_PER);

    always_comb begin
        per_eff = (period < PER_FLOOR) ? PER_FLOOR : period;
        wrap    = (count >= per_eff - 1'b1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count <= '0;
        end else if (wrap) begin
            count <= '0;
        end else begin
            count <= count + 1'b1;
        end
    end
endmodule

// File: rtl/pph_duty_calc.sv
module pph_duty_calc #(
    parameter int PERIOD_W = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wrap,
    input  logic [PERIOD_W-1:0]        per_eff,
    input  logic [pph_pkg::DUTY_W-1:0] duty,
    output logic [PERIOD_W-1:0]        on_time
);
    import pph_pkg::*;

    localparam int PROD_W = PERIOD_W + DUTY_W;
    localparam logic [DUTY_W-1:0] LO = DUTY_W'(DUTY_LO);
    localparam logic [DUTY_W-1:0] HI = DUTY_W'(DUTY_HI);

    logic [DUTY_W-1:0] duty_clamped;
    logic [PROD_W-1:0] product;
    logic [PROD_W-1:0] scaled;

    always_comb begin
        if (duty < LO) begin
            duty_clamped = LO;
        end else if (duty > HI) begin
            duty_clamped = HI;
        end else begin
            duty_clamped = duty;
        end
        product = PROD_W'(per_eff) * PROD_W'(duty_clamped);
        scaled  = product / PROD_W'(100);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            on_time <= '0;
        end else if (wrap) begin
            on_time <= scaled[PERIOD_W-1:0];
        end
    end
endmodule

// File: rtl/pph_sequencer.sv
module pph_sequencer #(
    parameter int PULL_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic [1:0]        delay_sel,
    input  logic [PULL_W-1:0] pull_len,
    input  logic              pwm_level,
    output logic              gate,
    output logic [1:0]        mode
);
    import pph_pkg::*;

    pph_state_t        state, state_nx;
    logic [PULL_W-1:0] timer, timer_nx;
    logic [PULL_W:0]   elapsed;
    logic              pull_done;

    always_comb begin
        elapsed   = {1'b0, timer} + 1'b1;
        pull_done = (elapsed >= {1'b0, pull_len});
        state_nx  = state;
        timer_nx  = '0;
        unique case (state)
            ST_OFF: begin
                if (enable) begin
                    state_nx = (delay_sel == SEL_MINIMUM) ? ST_PWM : ST_PULLIN;
                end
            end
            ST_PULLIN: begin
                if (!enable) begin
                    state_nx = ST_OFF;
                end else if (delay_sel == SEL_MINIMUM) begin
                    state_nx = ST_PWM;
                end else if (delay_sel == SEL_INFINITE) begin
                    state_nx = ST_PULLIN;
                end else if (pull_done) begin
                    state_nx = ST_PWM;
                end else begin
                    timer_nx = elapsed[PULL_W-1:0];
                end
            end
            ST_PWM: begin
                if (!enable) begin
                    state_nx = ST_OFF;
                end
            end
            default: state_nx = ST_OFF;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_OFF;
            timer <= '0;
        end else begin
            state <= state_nx;
            timer <= timer_nx;
        end
    end

    always_comb begin
        mode = state;
        unique case (state)
            ST_OFF:    gate = 1'b0;
            ST_PULLIN: gate = 1'b1;
            ST_PWM:    gate = pwm_level;
            default:   gate = 1'b0;
        endcase
    end
endmodule

// File: rtl/pullin_pwm_ctrl.sv
module pullin_pwm_ctrl #(
    parameter int PERIOD_W = 16,
    parameter int PULL_W   = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                enable,
    input  logic [PULL_W-1:0]   pull_len,
    input  logic [1:0]          delay_sel,
    input  logic [PERIOD_W-1:0] period,
    input  logic [6:0]          duty,
    output logic                gate,
    output logic [1:0]          mode
);
    logic [PERIOD_W-1:0] count;
    logic [PERIOD_W-1:0] per_eff;
    logic [PERIOD_W-1:0] on_time;
    logic                wrap;
    logic                pwm_level;

    pph_oscillator #(.PERIOD_W(PERIOD_W)) u_osc (
        .clk     (clk),
        .rst_n   (rst_n),
        .period  (period),
        .count   (count),
        .per_eff (per_eff),
        .wrap    (wrap)
    );

    pph_duty_calc #(.PERIOD_W(PERIOD_W)) u_duty (
        .clk     (clk),
        .rst_n   (rst_n),
        .wrap    (wrap),
        .per_eff (per_eff),
        .duty    (duty),
        .on_time (on_time)
    );

    assign pwm_level = (count < on_time);

    pph_sequencer #(.PULL_W(PULL_W)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable    (enable),
        .delay_sel (delay_sel),
        .pull_len  (pull_len),
        .pwm_level (pwm_level),
        .gate      (gate),
        .mode      (mode)
    );
endmodule

// File: rtl/pullin_pwm_ctrl_checker.sv
module pullin_pwm_ctrl_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       enable,
    input logic [1:0] delay_sel,
    input logic       gate,
    input logic [1:0] mode
);
    a_r1_off_after_drop: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (!gate && mode == 2'b00));

    a_r2_pullin_gate_on: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'b01) |-> gate);

    a_r2_timed_rise_enters_pullin: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && mode == 2'b00 && delay_sel == 2'b00) |=> (mode == 2'b01));

    a_r6_infinite_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && delay_sel == 2'b10 && mode != 2'b10) |=> (mode == 2'b01));

    a_r7_minimum_fast: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && delay_sel == 2'b01 && mode != 2'b10) |=> (mode == 2'b10));

    a_r9_mode_legal: assert property (@(posedge clk) disable iff (!rst_n)
        mode != 2'b11);

    a_r1_off_gate_low: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'b00) |-> !gate);
endmodule

bind pullin_pwm_ctrl pullin_pwm_ctrl_checker u_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .enable    (enable),
    .delay_sel (delay_sel),
    .gate      (gate),
    .mode      (mode)
);

// File: tb/test_pullin_pwm_ctrl.sv
module test_pullin_pwm_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int PW = 16;
    localparam int LW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          enable = 1'b0;
    logic [LW-1:0] pull_len = '0;
    logic [1:0]    delay_sel = 2'b00;
    logic [PW-1:0] period = 16'd20;
    logic [6:0]    duty = 7'd50;
    logic          gate;
    logic [1:0]    mode;

    int checks = 0;
    int fails = 0;
    string cur_req = "R1";

    // reference model state
    int m_cnt = 0, m_ton = 0, m_state = 0, m_timer = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pullin_pwm_ctrl #(.PERIOD_W(PW), .PULL_W(LW)) i_pullin_pwm_ctrl (
        .clk(clk), .rst_n(rst_n), .enable(enable), .pull_len(pull_len),
        .delay_sel(delay_sel), .period(period), .duty(duty),
        .gate(gate), .mode(mode)
    );

    function automatic int eff_period(int p);
        return (p < 2) ? 2 : p;
    endfunction

    function automatic int clamp_duty(int d);
        if (d < 10) return 10;
        if (d > 90) return 90;
        return d;
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_cnt = 0; m_ton = 0; m_state = 0; m_timer = 0;
        end else begin
            int p, nstate, ntimer;
            p = eff_period(int'(period));
            nstate = m_state;
            ntimer = 0;
            if (m_state == 0) begin
                if (enable) nstate = (delay_sel == 2'b01) ? 2 : 1;
            end else if (m_state == 1) begin
                if (!enable) nstate = 0;
                else if (delay_sel == 2'b01) nstate = 2;
                else if (delay_sel == 2'b10) nstate = 1;
                else if (m_timer + 1 >= int'(pull_len)) nstate = 2;
                else ntimer = m_timer + 1;
            end else begin
                if (!enable) nstate = 0;
            end
            if (m_cnt >= p - 1) begin
                m_cnt = 0;
                m_ton = (p * clamp_duty(int'(duty))) / 100;
            end else begin
                m_cnt = m_cnt + 1;
            end
            m_state = nstate;
            m_timer = ntimer;
        end
    end

    always @(negedge clk) begin
        if (rst_n) begin
            logic exp_gate;
            exp_gate = (m_state == 1) || (m_state == 2 && m_cnt < m_ton);
            checks++;
            if (gate !== exp_gate || mode !== 2'(m_state)) begin
                fails++;
                $display("FAIL %s: gate=%0b mode=%0d expected gate=%0b mode=%0d",
                         cur_req, gate, mode, exp_gate, m_state);
            end
        end
    end

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    // count gate-high clocks in an n-clock window
    task automatic count_high(input int n, output int hi);
        hi = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            #1;
            if (gate) hi++;
        end
    endtask

    // clocks of continuous gate-high pull-in after rising enable
    task automatic measure_pullin(output int len);
        len = 0;
        @(negedge clk);
        enable = 1'b1;
        @(negedge clk);
        #1;
        while (mode == 2'b01 && len < 1000) begin
            len++;
            @(negedge clk);
            #1;
        end
    endtask

    function automatic void summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endfunction

    initial begin
        #(CLK_PERIOD * 150000);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        int hi, len;
        #(CLK_PERIOD * 3 + 2);
        check("R9 reset mode", int'(mode), 0);
        check("R1 reset gate", int'(gate), 0);
        rst_n = 1'b1;
        cycles(5);

        // R2 timed pull-in
        cur_req = "R2";
        pull_len = 16'd7; delay_sel = 2'b00; period = 16'd20; duty = 7'd50;
        measure_pullin(len);
        check("R2 pull-in length", len, 7);
        check("R2 mode after pull-in", int'(mode), 2);

        // R4 mid-range on-time
        cur_req = "R4";
        cycles(25);
        count_high(20, hi);
        check("R4 duty 50 of 20", hi, 10);
        duty = 7'd25;
        cur_req = "R5";
        cycles(45);
        count_high(20, hi);
        check("R5 duty 25 of 20", hi, 5);

        // R4 clamp low and high
        cur_req = "R4";
        duty = 7'd3;
        cycles(45);
        count_high(20, hi);
        check("R4 clamp low", hi, 2);
        duty = 7'd120;
        cycles(45);
        count_high(20, hi);
        check("R4 clamp high", hi, 18);

        // R1 drop
        cur_req = "R1";
        enable = 1'b0;
        cycles(1);
        #1;
        check("R1 gate after drop", int'(gate), 0);
        check("R1 mode after drop", int'(mode), 0);

        // R3 rises at various counter phases, period 13
        cur_req = "R3";
        period = 16'd13; duty = 7'd60; pull_len = 16'd3;
        for (int k = 0; k < 5; k++) begin
            cycles(k + 2);
            enable = 1'b1;
            cycles(30);
            enable = 1'b0;
        end

        // R6 infinite
        cur_req = "R6";
        delay_sel = 2'b10;
        cycles(3);
        enable = 1'b1;
        count_high(60, hi);
        check("R6 gate continuous", hi, 60);
        check("R6 still pull-in", int'(mode), 1);
        // R7 select minimum during pull-in
        cur_req = "R7";
        delay_sel = 2'b01;
        cycles(1);
        #1;
        check("R7 leave pull-in", int'(mode), 2);
        enable = 1'b0;
        cycles(3);
        enable = 1'b1;
        cycles(1);
        #1;
        check("R7 minimum enters PWM", int'(mode), 2);
        enable = 1'b0;
        cycles(3);

        // R8 drop during pull-in then fresh full interval
        cur_req = "R8";
        delay_sel = 2'b00; pull_len = 16'd9;
        enable = 1'b1;
        cycles(5);
        enable = 1'b0;
        cycles(2);
        enable = 1'b0;
        measure_pullin(len);
        check("R8 fresh pull-in", len, 9);
        enable = 1'b0;
        cycles(2);

        // R10 period below 2
        cur_req = "R10";
        period = 16'd1; duty = 7'd50; pull_len = 16'd1;
        enable = 1'b1;
        cycles(10);
        count_high(2, hi);
        check("R10 period 1 acts as 2", hi, 1);
        period = 16'd0;
        cycles(10);
        count_high(4, hi);
        check("R10 period 0 acts as 2", hi, 2);
        enable = 1'b0;
        cycles(4);

        summary();
        $finish;
    end
endmodule